// File: doc/BRIEF.md
# Timer Capture/Compare Channel Bank

This block groups eight 16-bit timer channels around one free-running 16-bit counter that advances on a tick-enable input. Three channels are fixed capture channels: each one samples the counter when a selected transition appears on its input pin. Four channels are fixed compare channels: each one fires when the counter steps onto its register value and then changes its output pin in a configured way. One more channel is shared. A single mode bit turns it into a fourth capture channel or a fifth compare channel.

Software reaches the block through one flat register window. Each write is a single cycle with `wrEn` high, and reads are combinational on the same address bus. Every channel event sets a sticky flag that software clears by writing ones. Counter wrap has its own flag.

Top module: `capcmp_bank`

## Requirements
- R1: After reset the counter reads 0x0000, all eight channel registers (addresses 8 to 15) read 0xFFFF, all flags read 0, the mode bit reads 0 and every compare pin is 0.
- R2: The counter (address 0, read-only) adds one at each clock edge where `tickEn` is high and holds otherwise. A step from 0xFFFF goes to 0x0000 and sets the overflow flag (flag register bit 8).
- R3: Writes to the fixed capture registers (addresses 8, 9, 10) are ignored.
- R4: Capture channel k (k = 0..2 fixed at addresses 8+k, k = 3 shared at address 11) is configured by bits [2k+1:2k] of address 2: 00 off, 01 rising only, 10 falling only, 11 both. On a selected pin transition, the register loads the counter value at the third clock edge after the pin change, and flag bit k is set.
- R5: Compare registers 1 to 4 (addresses 12 to 15) are written and read back by software.
- R6: Compare channel j (j = 0..3 at addresses 12+j, j = 4 the shared one at address 11) fires at the edge where `tickEn` moves the counter onto its register value. At that same edge, pin `ocPin[j]` follows bits [2j+1:2j] of address 3: 00 unchanged, 01 toggled, 10 cleared, 11 set. Flag bit 4+j is set (bit 3 for j = 4).
- R7: Flags at address 4 are sticky. Writing a 1 to a bit clears it. When an event and a clear land in the same cycle, the flag stays set.
- R8: Bit 0 of address 1 selects the shared channel's role: 0 makes it compare 5, 1 makes it capture 4.
- R9: In capture role the shared channel ignores software writes to its register, raises no compare events, and holds `ocPin[4]`.
- R10: In compare role the shared channel ignores transitions on `icPin[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Counter advance enable |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr` |
| icPin | input | 4 | Capture pins; bit 3 feeds the shared channel |
| ocPin | output | 5 | Compare pins; bit 4 is driven by the shared channel |
| chanFlags | output | 8 | Per-channel event flags, same bit order as address 4 |
| ovfFlag | output | 1 | Counter wrap flag |

## Verification
The assertions assume that the only way a flag can drop is a write to the flag address. They also assume that the mode bit changes only through a register write, so a pin hold in capture role can be judged from the mode seen one cycle earlier. The stimulus sets the mode and configuration only with `tickEn` low. It changes a capture pin only after the previous change has passed all synchronizer stages. It places every compare target ahead of the counter, so each match comes from a known number of ticks.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
  localparam int CNT_W = 16;
  localparam int N_IC = 3;
  localparam int N_OC = 4;
  localparam int N_CAP = N_IC + 1;
  localparam int N_CMP = N_OC + 1;
  localparam int N_CH = N_IC + 1 + N_OC;
  localparam int ADDR_W = 4;
  localparam int SYNC_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CNT = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_CAPCFG = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMPCFG = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 4'd4;
  localparam int CHAN_BASE = 8;

  typedef struct packed {
    logic [N_CH-1:0] chanWr;
    logic [CNT_W-1:0] wrVal;
    logic sharedCap;
    logic [2*N_CAP-1:0] capCfg;
    logic [2*N_CMP-1:0] cmpCfg;
  } ccbStrobe_t;
endpackage

// File: rtl/ccbCtrl.sv
module ccbCtrl
  import ccb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [N_CH-1:0] chanEvt,
  input  logic ovfEvt,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [N_CH-1:0][CNT_W-1:0] chanRegs,
  output ccbStrobe_t stb,
  output logic [N_CH-1:0] chanFlags,
  output logic ovfFlag,
  output logic [CNT_W-1:0] rdData
);
  logic modeReg;
  logic [2*N_CAP-1:0] capCfgReg;
  logic [2*N_CMP-1:0] cmpCfgReg;
  logic [CNT_W-1:0] clrMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= 1'b0;
      capCfgReg <= '0;
      cmpCfgReg <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_CTRL) modeReg <= wrData[0];
      if (addr == ADDR_CAPCFG) capCfgReg <= wrData[2*N_CAP-1:0];
      if (addr == ADDR_CMPCFG) cmpCfgReg <= wrData[2*N_CMP-1:0];
    end
  end

  assign clrMask = (wrEn && addr == ADDR_FLAG) ? wrData : '0;

  // An event in the same cycle as a clear wins: the set term is ORed in last.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanFlags <= '0;
      ovfFlag <= 1'b0;
    end else begin
      chanFlags <= (chanFlags & ~clrMask[N_CH-1:0]) | chanEvt;
      ovfFlag <= (ovfFlag & ~clrMask[N_CH]) | ovfEvt;
    end
  end

  always_comb begin
    stb.wrVal = wrData;
    stb.sharedCap = modeReg;
    stb.capCfg = capCfgReg;
    stb.cmpCfg = cmpCfgReg;
    for (int i = 0; i < N_CH; i++) begin
      stb.chanWr[i] = wrEn && (addr == ADDR_W'(CHAN_BASE + i))
                      && ((i > N_IC) || ((i == N_IC) && !modeReg));
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CNT: rdData = cntVal;
      ADDR_CTRL: rdData = CNT_W'(modeReg);
      ADDR_CAPCFG: rdData = CNT_W'(capCfgReg);
      ADDR_CMPCFG: rdData = CNT_W'(cmpCfgReg);
      ADDR_FLAG: rdData = CNT_W'({ovfFlag, chanFlags});
      default: begin
        for (int i = 0; i < N_CH; i++) begin
          if (addr == ADDR_W'(CHAN_BASE + i)) rdData = chanRegs[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/ccbDatapath.sv
module ccbDatapath
  import ccb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic [N_CAP-1:0] icPin,
  input  ccbStrobe_t stb,
  output logic [CNT_W-1:0] cntVal,
  output logic ovfEvt,
  output logic [N_CH-1:0] chanEvt,
  output logic [N_CH-1:0][CNT_W-1:0] chanRegs,
  output logic [N_CMP-1:0] ocPin
);
  logic [CNT_W-1:0] cntNext;
  logic [N_CAP-1:0][SYNC_W-1:0] syncSh;
  logic [N_CH-1:0] capHitW;
  logic [N_CH-1:0] capLdCh;
  logic [N_CH-1:0] cmpHitCh;

  assign cntNext = cntVal + CNT_W'(1);
  assign ovfEvt = tickEn && (cntVal == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntVal <= '0;
    else if (tickEn) cntVal <= cntNext;
  end

  // Two synchronizer stages, then one more stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncSh <= '0;
    else begin
      for (int c = 0; c < N_CAP; c++) begin
        syncSh[c] <= {syncSh[c][SYNC_W-2:0], icPin[c]};
      end
    end
  end

  always_comb begin
    capHitW = '0;
    for (int c = 0; c < N_CAP; c++) begin
      capHitW[c] = (stb.capCfg[2*c] && syncSh[c][1] && !syncSh[c][2])
                || (stb.capCfg[2*c+1] && !syncSh[c][1] && syncSh[c][2]);
    end
  end

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      capLdCh[i] = capHitW[i] && ((i < N_IC) || ((i == N_IC) && stb.sharedCap));
      cmpHitCh[i] = tickEn && (cntNext == chanRegs[i])
                    && ((i > N_IC) || ((i == N_IC) && !stb.sharedCap));
    end
  end

  assign chanEvt = capLdCh | cmpHitCh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chanRegs <= '1;
    else begin
      for (int i = 0; i < N_CH; i++) begin
        if (capLdCh[i]) chanRegs[i] <= cntVal;
        else if (stb.chanWr[i]) chanRegs[i] <= stb.wrVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ocPin <= '0;
    else begin
      for (int j = 0; j < N_CMP; j++) begin
        if (cmpHitCh[(j == N_OC) ? N_IC : (N_IC + 1 + j)]) begin
          case (stb.cmpCfg[2*j +: 2])
            2'b01: ocPin[j] <= ~ocPin[j];
            2'b10: ocPin[j] <= 1'b0;
            2'b11: ocPin[j] <= 1'b1;
            default: ocPin[j] <= ocPin[j];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/capcmp_bank.sv
module capcmp_bank
  import ccb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  logic [N_CAP-1:0] icPin,
  output logic [N_CMP-1:0] ocPin,
  output logic [N_CH-1:0] chanFlags,
  output logic ovfFlag
);
  ccbStrobe_t stb;
  logic [CNT_W-1:0] cntVal;
  logic ovfEvt;
  logic [N_CH-1:0] chanEvt;
  logic [N_CH-1:0][CNT_W-1:0] chanRegs;

  ccbCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .chanEvt(chanEvt), .ovfEvt(ovfEvt), .cntVal(cntVal), .chanRegs(chanRegs),
    .stb(stb), .chanFlags(chanFlags), .ovfFlag(ovfFlag), .rdData(rdData)
  );

  ccbDatapath u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .icPin(icPin), .stb(stb),
    .cntVal(cntVal), .ovfEvt(ovfEvt), .chanEvt(chanEvt), .chanRegs(chanRegs),
    .ocPin(ocPin)
  );
endmodule

// File: rtl/ccbChecker.sv
module ccbChecker
  import ccb_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0] cntVal,
  input logic ovfFlag,
  input logic [N_CH-1:0] chanFlags,
  input logic [N_CMP-1:0] ocPin,
  input logic sharedCap
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cntVal));

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> (cntVal == $past(cntVal) + CNT_W'(1)));

  a_r2_wrap_flag: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && cntVal == '1) |=> ovfFlag);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_FLAG) |=> ((chanFlags & $past(chanFlags)) == $past(chanFlags)));

  a_r9_pin_hold: assert property (@(posedge clk) disable iff (!rstN)
    sharedCap |=> $stable(ocPin[N_OC]));
endmodule

bind capcmp_bank ccbChecker u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
  .cntVal(cntVal), .ovfFlag(ovfFlag), .chanFlags(chanFlags), .ocPin(ocPin),
  .sharedCap(stb.sharedCap)
);

// File: tb/tb_capcmp_bank.sv
module tb_capcmp_bank;
  import ccb_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, tickEn, wrEn;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0] wrData, rdData;
  logic [N_CAP-1:0] icPin;
  logic [N_CMP-1:0] ocPin;
  logic [N_CH-1:0] chanFlags;
  logic ovfFlag;

  capcmp_bank dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .icPin(icPin), .ocPin(ocPin),
    .chanFlags(chanFlags), .ovfFlag(ovfFlag)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] expCnt = 16'd0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = rdData;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
    expCnt = expCnt + 16'(n);
  endtask

  function automatic int cmpAddr(input int j);
    return (j == 4) ? 11 : 12 + j;
  endfunction

  function automatic int cmpFlag(input int j);
    return (j == 4) ? 3 : 4 + j;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, old, tgt;
    logic pinB, expPin, hit;
    rstN = 1'b0; tickEn = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0; icPin = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(0, v); chk("R1 counter", 32'(v), 32'h0);
    for (int i = 8; i < 16; i++) begin
      rd(i, v); chk("R1 channel register", 32'(v), 32'hFFFF);
    end
    rd(4, v); chk("R1 flags", 32'(v), 32'h0);
    rd(1, v); chk("R1 mode", 32'(v), 32'h0);
    chk("R1 pins", 32'(ocPin), 32'h0);

    // R2 hold and step
    repeat (5) @(negedge clk);
    rd(0, v); chk("R2 hold without tick", 32'(v), 32'h0);
    ticks(7);
    rd(0, v); chk("R2 step count", 32'(v), 32'(expCnt));

    // R5 readback, R3 read-only capture
    wr(12, 16'hA5C3); rd(12, v); chk("R5 compare readback", 32'(v), 32'hA5C3);
    wr(15, 16'h5A3C); rd(15, v); chk("R5 compare readback", 32'(v), 32'h5A3C);
    for (int c = 0; c < 3; c++) begin
      wr(8 + c, 16'h1111); rd(8 + c, v); chk("R3 capture write ignored", 32'(v), 32'hFFFF);
    end

    // R6 compare sweep over all channels and actions (R8 mode 0 for shared)
    for (int j = 0; j < 5; j++) begin
      for (int a = 0; a < 4; a++) begin
        wr(3, 16'(a << (2 * j)));
        pinB = ocPin[j];
        tgt = expCnt + 16'd3;
        wr(cmpAddr(j), tgt);
        ticks(2);
        chk("R6 pin before match", 32'(ocPin[j]), 32'(pinB));
        rd(4, v); chk("R7 flag before match", 32'(v[cmpFlag(j)]), 32'h0);
        ticks(1);
        rd(0, v); chk("R6 counter at target", 32'(v), 32'(tgt));
        case (a)
          0: expPin = pinB;
          1: expPin = ~pinB;
          2: expPin = 1'b0;
          default: expPin = 1'b1;
        endcase
        chk("R6 pin action", 32'(ocPin[j]), 32'(expPin));
        rd(4, v); chk("R6 match flag", 32'(v[cmpFlag(j)]), 32'h1);
        wr(4, 16'(1 << cmpFlag(j)));
        rd(4, v); chk("R7 write-one clear", 32'(v[cmpFlag(j)]), 32'h0);
      end
    end

    // R7 set wins over clear
    wr(3, 16'h0);
    tgt = expCnt + 16'd1;
    wr(12, tgt);
    @(negedge clk);
    tickEn = 1'b1; wrEn = 1'b1; addr = 4'd4; wrData = 16'h0010;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    expCnt = expCnt + 16'd1;
    rd(4, v); chk("R7 set beats clear", 32'(v[4]), 32'h1);
    wr(4, 16'h0010); rd(4, v); chk("R7 clear after", 32'(v[4]), 32'h0);

    // R4 capture sweep; channel 3 uses shared capture role (R8)
    for (int c = 0; c < 4; c++) begin
      if (c == 3) begin
        wr(1, 16'h1); rd(1, v); chk("R8 mode readback", 32'(v), 32'h1);
      end
      for (int e = 0; e < 4; e++) begin
        for (int d = 0; d < 2; d++) begin
          ticks(1);
          wr(2, 16'(e << (2 * c)));
          rd(8 + c, old);
          @(negedge clk);
          icPin[c] = ~icPin[c];
          repeat (4) @(negedge clk);
          hit = icPin[c] ? e[0] : e[1];
          rd(8 + c, v);
          chk((c == 3) ? "R8 R4 shared capture" : "R4 capture value",
              32'(v), hit ? 32'(expCnt) : 32'(old));
          rd(4, v); chk("R4 capture flag", 32'(v[c]), 32'(hit));
          wr(4, 16'(1 << c));
        end
      end
    end

    // R9 shared channel in capture role
    rd(11, old);
    wr(11, 16'h0BAD); rd(11, v); chk("R9 write ignored in capture role", 32'(v), 32'(old));
    wr(2, 16'h0);
    wr(1, 16'h0);
    wr(3, 16'h0100);
    tgt = expCnt + 16'd3;
    wr(11, tgt);
    wr(1, 16'h1);
    pinB = ocPin[4];
    ticks(3);
    chk("R9 pin holds", 32'(ocPin[4]), 32'(pinB));
    rd(4, v); chk("R9 no compare flag", 32'(v[3]), 32'h0);
    rd(11, v); chk("R9 register kept", 32'(v), 32'(tgt));

    // R10 shared channel in compare role ignores its pin
    wr(1, 16'h0);
    wr(2, 16'h00C0);
    rd(11, old);
    @(negedge clk);
    icPin[3] = ~icPin[3];
    repeat (4) @(negedge clk);
    rd(11, v); chk("R10 capture pin ignored", 32'(v), 32'(old));
    rd(4, v); chk("R10 no capture flag", 32'(v[3]), 32'h0);

    // R2 wrap and overflow flag
    wr(3, 16'h0);
    wr(4, 16'h00FF);
    ticks(65535 - int'(expCnt));
    rd(0, v); chk("R2 counter at top", 32'(v), 32'hFFFF);
    rd(4, v); chk("R2 no overflow yet", 32'(v[8]), 32'h0);
    ticks(1);
    rd(0, v); chk("R2 wrap to zero", 32'(v), 32'h0);
    rd(4, v); chk("R2 overflow flag", 32'(v[8]), 32'h1);
    chk("R2 overflow port", 32'(ovfFlag), 32'h1);
    wr(4, 16'h0100);
    rd(4, v); chk("R7 overflow clear", 32'(v[8]), 32'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule